// File: doc/BRIEF.md
# Dual-Bus Bayer Pixel Capture

This block takes the parallel output of a colour image sensor running in 16-bit mode and turns it into a tagged sample stream. Two 8-bit buses deliver two raw Bayer samples on every qualified pixel clock. Rows alternate between a red/green pair and a green/blue pair. The block rebuilds the frame, row and column position from the frame sync and line-valid strobes. Each pair it emits carries its colour kind, its row and its pair column. It also raises end-of-line and end-of-frame pulses.

All logic runs on `clk`, the pixel-domain clock. The input `pix_tick_i` marks the edges at which the sensor presents a new pair, and data is taken only on those edges while the line strobe is high. The sensor cannot be paused. When the downstream side stalls, new pairs are dropped and a sticky flag records the loss.

The field flag is set by measuring the frame-sync pulse in clock cycles. The sensor makes the pulse longer on odd frames, so the flag follows the pulse length rather than toggling on its own. Every frame is still a full-height progressive image. Lines that end early and lines beyond the configured row count are flagged.

Top module: `cam_bayer_capture`

## Requirements
- R1: After reset, every output is 0, including out_valid_o, the pulses and all flags.
- R2: A pair is taken only at a clock edge where href_i and pix_tick_i are both high. It appears on the output with out_valid_o high after that edge, with out_s0_o = bus_y_i and out_s1_o = bus_uv_i.
- R3: out_kind_o = 0 means s0 is red and s1 is green; 1 means s0 is green and s1 is blue. out_kind_o equals bit 0 of out_row_o XOR PHASE_INV, so the first row of a frame is red/green when PHASE_INV = 0.
- R4: A rising edge of vsync_i restarts the row count at 0 and the column count at 0. The next line captured is row 0.
- R5: out_col_o is the index of the pair within its line and restarts at 0 on every rising edge of href_i. Ticks after PAIRS_PER_LINE pairs in one line produce no output.
- R6: The row count advances by one at every falling edge of href_i.
- R7: eol_o is a one-cycle pulse issued in the same cycle as the pair with column PAIRS_PER_LINE-1. eof_o pulses together with eol_o when that line is row ROWS-1.
- R8: If href_i falls after fewer than PAIRS_PER_LINE pairs, short_line_o pulses for one cycle after the edge that sees the fall, and that line raises no eol_o.
- R9: A line that starts with the row count at ROWS or above produces no pairs. It sets row_overrun_o, which stays high until the edge that sees the next rising vsync_i.
- R10: A pair arriving while out_valid_o is high and out_ready_i is low is dropped. The held pair stays unchanged, and overflow_o goes high and stays high until reset.
- R11: On the edge that sees vsync_i fall, field_odd_o becomes 1 if vsync_i was high for at least ODD_MIN_LEN cycles, and 0 otherwise. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | Frame sync; a rising edge starts a frame |
| href_i | input | 1 | Line valid strobe |
| pix_tick_i | input | 1 | Qualified pixel clock edge marker |
| bus_y_i | input | DW | First sample bus |
| bus_uv_i | input | DW | Second sample bus |
| out_ready_i | input | 1 | Downstream ready |
| out_valid_o | output | 1 | Output pair valid |
| out_s0_o | output | DW | First sample of the pair |
| out_s1_o | output | DW | Second sample of the pair |
| out_kind_o | output | 1 | 0 red/green, 1 green/blue |
| out_row_o | output | ROW_W | Row of the pair |
| out_col_o | output | COL_W | Pair column within the line |
| field_odd_o | output | 1 | Measured field flag |
| eol_o | output | 1 | End-of-line pulse |
| eof_o | output | 1 | End-of-frame pulse |
| short_line_o | output | 1 | Short-line pulse |
| row_overrun_o | output | 1 | Too many lines this frame |
| overflow_o | output | 1 | Sticky pair-dropped flag |

## Verification
Each output is registered once between the sampling edge and the port. A pair, eol_o and eof_o are due one edge after the qualified tick. short_line_o is due one edge after the first edge that sees href_i low, and field_odd_o one edge after the first edge that sees vsync_i low. The bench drives inputs on the falling clock edge. It updates its expected state from the same inputs at the rising edge and compares every output at the following falling edge, so each result is checked exactly one register stage after its cause.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  typedef enum logic {
    PAIR_RG = 1'b0,
    PAIR_GB = 1'b1
  } pair_kind_e;

  // colour pair of a row from its parity and the phase option
  function automatic pair_kind_e kind_of_row(input logic row_lsb, input logic invert);
    return pair_kind_e'(row_lsb ^ invert);
  endfunction

  // field decision from the measured frame-sync length
  function automatic logic pulse_is_odd(input logic [31:0] len, input logic [31:0] thr);
    return len >= thr;
  endfunction

  // a line is complete when the configured pair count was taken
  function automatic logic line_full(input logic [31:0] got, input logic [31:0] need);
    return got >= need;
  endfunction

endpackage

// File: rtl/cam_sync_tracker.sv
module cam_sync_tracker #(
  parameter int LEN_W   = 8,
  parameter int ODD_MIN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  output logic frame_start_o,
  output logic vs_fall_o,
  output logic field_odd_o
);
  import cam_cap_pkg::*;

  logic             vs_q;
  logic [LEN_W-1:0] len_q;

  assign frame_start_o = vsync_i & ~vs_q;
  assign vs_fall_o     = ~vsync_i & vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q        <= 1'b0;
      len_q       <= '0;
      field_odd_o <= 1'b0;
    end else begin
      vs_q <= vsync_i;
      if (frame_start_o)
        len_q <= LEN_W'(1);
      else if (vsync_i && len_q != '1)
        len_q <= len_q + 1'b1;
      if (vs_fall_o)
        field_odd_o <= pulse_is_odd(32'(len_q), 32'(ODD_MIN));
    end
  end

endmodule

// File: rtl/cam_line_tracker.sv
module cam_line_tracker #(
  parameter int PAIRS = 16,
  parameter int ROWS  = 12,
  parameter int COL_W = 5,
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             href_i,
  input  logic             tick_i,
  output logic             take_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             eol_o,
  output logic             eof_o,
  output logic             short_o,
  output logic             overrun_o
);
  import cam_cap_pkg::*;

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAIRS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_LIM  = ROW_W'(ROWS);

  logic             href_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             line_rise, line_fall, row_ok, room;

  assign line_rise = href_i & ~href_q;
  assign line_fall = ~href_i & href_q;

  assign row_o  = frame_start_i ? '0 : row_q;
  assign col_o  = (line_rise | frame_start_i) ? '0 : col_q;
  assign row_ok = row_o < ROW_LIM;
  assign room   = ~line_full(32'(col_o), 32'(PAIRS));
  assign take_o = href_i & tick_i & room & row_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      href_q    <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      eol_o     <= 1'b0;
      eof_o     <= 1'b0;
      short_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      href_q  <= href_i;
      col_q   <= col_o + COL_W'(take_o);
      eol_o   <= take_o && (col_o == LAST_COL);
      eof_o   <= take_o && (col_o == LAST_COL) && (row_o == LAST_ROW);
      short_o <= line_fall && !line_full(32'(col_q), 32'(PAIRS)) && (row_q < ROW_LIM);
      if (line_fall && !frame_start_i)
        row_q <= (row_q == '1) ? row_q : row_q + 1'b1;
      else
        row_q <= row_o;
      if (frame_start_i)
        overrun_o <= 1'b0;
      else if (line_rise && !row_ok)
        overrun_o <= 1'b1;
    end
  end

endmodule

// File: rtl/cam_out_stage.sv
module cam_out_stage #(
  parameter int DW    = 8,
  parameter int COL_W = 5,
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [DW-1:0]    s0_i,
  input  logic [DW-1:0]    s1_i,
  input  logic             kind_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [DW-1:0]    s0_o,
  output logic [DW-1:0]    s1_o,
  output logic             kind_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             drop_o,
  output logic             overflow_o
);
  logic slot_free;

  assign slot_free = ~valid_o | ready_i;
  assign drop_o    = take_i & ~slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      s0_o       <= '0;
      s1_o       <= '0;
      kind_o     <= 1'b0;
      col_o      <= '0;
      row_o      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (take_i && slot_free) begin
        valid_o <= 1'b1;
        s0_o    <= s0_i;
        s1_o    <= s1_i;
        kind_o  <= kind_i;
        col_o   <= col_i;
        row_o   <= row_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
      if (drop_o)
        overflow_o <= 1'b1;
    end
  end

endmodule

// File: rtl/cam_bayer_capture.sv
module cam_bayer_capture #(
  parameter int DW             = 8,
  parameter int PAIRS_PER_LINE = 16,
  parameter int ROWS           = 12,
  parameter int ODD_MIN_LEN    = 6,
  parameter int LEN_W          = 8,
  parameter bit PHASE_INV      = 1'b0,
  localparam int COL_W = $clog2(PAIRS_PER_LINE + 1),
  localparam int ROW_W = $clog2(ROWS + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_i,
  input  logic             href_i,
  input  logic             pix_tick_i,
  input  logic [DW-1:0]    bus_y_i,
  input  logic [DW-1:0]    bus_uv_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_s0_o,
  output logic [DW-1:0]    out_s1_o,
  output logic             out_kind_o,
  output logic [ROW_W-1:0] out_row_o,
  output logic [COL_W-1:0] out_col_o,
  output logic             field_odd_o,
  output logic             eol_o,
  output logic             eof_o,
  output logic             short_line_o,
  output logic             row_overrun_o,
  output logic             overflow_o
);
  import cam_cap_pkg::*;

  logic             frame_start_w, vs_fall_w, take_w, drop_w;
  logic [COL_W-1:0] col_w;
  logic [ROW_W-1:0] row_w;
  pair_kind_e       kind_w;

  cam_sync_tracker #(.LEN_W(LEN_W), .ODD_MIN(ODD_MIN_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i),
    .frame_start_o(frame_start_w), .vs_fall_o(vs_fall_w), .field_odd_o(field_odd_o)
  );

  cam_line_tracker #(.PAIRS(PAIRS_PER_LINE), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)) u_line (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_w), .href_i(href_i),
    .tick_i(pix_tick_i), .take_o(take_w), .col_o(col_w), .row_o(row_w),
    .eol_o(eol_o), .eof_o(eof_o), .short_o(short_line_o), .overrun_o(row_overrun_o)
  );

  assign kind_w = kind_of_row(row_w[0], PHASE_INV);

  cam_out_stage #(.DW(DW), .COL_W(COL_W), .ROW_W(ROW_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take_i(take_w), .s0_i(bus_y_i), .s1_i(bus_uv_i),
    .kind_i(kind_w), .col_i(col_w), .row_i(row_w), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .s0_o(out_s0_o), .s1_o(out_s1_o), .kind_o(out_kind_o),
    .col_o(out_col_o), .row_o(out_row_o), .drop_o(drop_w), .overflow_o(overflow_o)
  );

endmodule

// File: rtl/cam_bayer_capture_chk.sv
module cam_bayer_capture_chk #(
  parameter int DW        = 8,
  parameter int PAIRS     = 16,
  parameter int ROWS      = 12,
  parameter bit PHASE_INV = 1'b0,
  parameter int COL_W     = 5,
  parameter int ROW_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             href_i,
  input logic             pix_tick_i,
  input logic             out_ready_i,
  input logic             out_valid_o,
  input logic [DW-1:0]    out_s0_o,
  input logic [DW-1:0]    out_s1_o,
  input logic             out_kind_o,
  input logic [ROW_W-1:0] out_row_o,
  input logic [COL_W-1:0] out_col_o,
  input logic             field_odd_o,
  input logic             eol_o,
  input logic             eof_o,
  input logic             overflow_o,
  input logic             drop_w,
  input logic             vs_fall_w
);
  AST_NEW_PAIR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(href_i && pix_tick_i)); // R2
  AST_KIND_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_kind_o == (out_row_o[0] ^ PHASE_INV))); // R3
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_col_o < COL_W'(PAIRS))); // R5
  AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> eol_o); // R7
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_row_o < ROW_W'(ROWS))); // R9
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_s0_o) && $stable(out_s1_o))); // R10
  AST_NO_OVERFLOW_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> overflow_o); // R10
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R10
  AST_FIELD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_odd_o) |-> $past(vs_fall_w)); // R11
endmodule

bind cam_bayer_capture cam_bayer_capture_chk #(
  .DW(DW), .PAIRS(PAIRS_PER_LINE), .ROWS(ROWS), .PHASE_INV(PHASE_INV),
  .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .href_i(href_i), .pix_tick_i(pix_tick_i),
  .out_ready_i(out_ready_i), .out_valid_o(out_valid_o), .out_s0_o(out_s0_o),
  .out_s1_o(out_s1_o), .out_kind_o(out_kind_o), .out_row_o(out_row_o),
  .out_col_o(out_col_o), .field_odd_o(field_odd_o), .eol_o(eol_o), .eof_o(eof_o),
  .overflow_o(overflow_o), .drop_w(drop_w), .vs_fall_w(vs_fall_w)
);

// File: tb/cam_bayer_capture_tb.sv
module cam_bayer_capture_tb;
  localparam int DW = 8, PAIRS = 8, ROWS = 4, ODD_MIN = 6, PHASE = 0;
  localparam int COL_W = $clog2(PAIRS + 1), ROW_W = $clog2(ROWS + 1) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vsync = 1'b0, href = 1'b0, tick = 1'b0, ready = 1'b1;
  logic [DW-1:0] by = '0, buv = '0;
  logic out_valid, out_kind, field_odd, eol, eof, short_l, overrun, ovf;
  logic [DW-1:0] s0, s1;
  logic [ROW_W-1:0] orow;
  logic [COL_W-1:0] ocol;

  always #4 clk = ~clk;

  cam_bayer_capture #(.DW(DW), .PAIRS_PER_LINE(PAIRS), .ROWS(ROWS),
    .ODD_MIN_LEN(ODD_MIN), .PHASE_INV(PHASE[0])) u_dut (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .href_i(href), .pix_tick_i(tick),
    .bus_y_i(by), .bus_uv_i(buv), .out_ready_i(ready), .out_valid_o(out_valid),
    .out_s0_o(s0), .out_s1_o(s1), .out_kind_o(out_kind), .out_row_o(orow),
    .out_col_o(ocol), .field_odd_o(field_odd), .eol_o(eol), .eof_o(eof),
    .short_line_o(short_l), .row_overrun_o(overrun), .overflow_o(ovf));

  int checks = 0, fails = 0;
  bit done = 0, checking = 0;
  int ready_mode = 0;

  // expected state, rebuilt from the requirements at each rising edge
  int  e_vs_prev, e_href_prev, e_len, e_pairs, e_row;
  bit  e_valid, e_kind, e_field, e_eol, e_eof, e_short, e_overrun, e_ovf;
  int  e_s0, e_s1, e_col, e_orow;

  function automatic bit kind_for(int row);
    return bit'((row % 2) != PHASE);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_vs_prev = 0; e_href_prev = 0; e_len = 0; e_pairs = 0; e_row = 0;
      e_valid = 0; e_kind = 0; e_field = 0; e_eol = 0; e_eof = 0; e_short = 0;
      e_overrun = 0; e_ovf = 0; e_s0 = 0; e_s1 = 0; e_col = 0; e_orow = 0;
    end else begin
      bit vs_up, vs_dn, ln_up, ln_dn, take;
      int row_now, col_now;
      vs_up = vsync && e_vs_prev == 0;
      vs_dn = !vsync && e_vs_prev == 1;
      ln_up = href && e_href_prev == 0;
      ln_dn = !href && e_href_prev == 1;
      if (vs_dn) e_field = (e_len >= ODD_MIN);                 // R11
      if (vs_up) e_len = 1; else if (vsync) e_len++;
      row_now = vs_up ? 0 : e_row;                              // R4
      col_now = (ln_up || vs_up) ? 0 : e_pairs;                 // R5
      take = href && tick && col_now < PAIRS && row_now < ROWS; // R2 R9
      e_short = ln_dn && e_pairs < PAIRS && e_row < ROWS;       // R8
      e_eol = take && col_now == PAIRS - 1;                     // R7
      e_eof = e_eol && row_now == ROWS - 1;
      if (vs_up) e_overrun = 0;
      else if (ln_up && row_now >= ROWS) e_overrun = 1;
      if (take && e_valid && !ready) e_ovf = 1;                 // R10
      if (take && (!e_valid || ready)) begin
        e_valid = 1; e_s0 = by; e_s1 = buv; e_col = col_now; e_orow = row_now;
        e_kind = kind_for(row_now);
      end else if (ready) e_valid = 0;
      e_pairs = col_now + (take ? 1 : 0);
      e_row = (ln_dn && !vs_up) ? row_now + 1 : row_now;        // R6
      e_vs_prev = vsync; e_href_prev = href;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && checking) begin
    chk(out_valid == e_valid, "R2 valid", out_valid, e_valid);
    if (e_valid && out_valid) begin
      chk(s0 == e_s0 && s1 == e_s1, "R2 data", {s0, s1}, {e_s0[7:0], e_s1[7:0]});
      chk(out_kind == e_kind, "R3 kind", out_kind, e_kind);
      chk(ocol == e_col, "R5 column", ocol, e_col);
      chk(orow == e_orow, "R4 R6 row", orow, e_orow);
    end
    chk(eol == e_eol && eof == e_eof, "R7 eol/eof", {eol, eof}, {e_eol, e_eof});
    chk(short_l == e_short, "R8 short line", short_l, e_short);
    chk(overrun == e_overrun, "R9 overrun", overrun, e_overrun);
    chk(ovf == e_ovf, "R10 overflow", ovf, e_ovf);
    chk(field_odd == e_field, "R11 field", field_odd, e_field);
  end

  task automatic step(bit v, bit h, bit t);
    @(negedge clk);
    vsync = v; href = h; tick = t;
    by = 8'($urandom); buv = 8'($urandom);
    case (ready_mode)
      0: ready = 1'b1;
      1: ready = ($urandom % 5) != 0;
      default: ready = 1'b0;
    endcase
  endtask

  // one line: npairs qualified ticks, extra ticks beyond that
  task automatic line(int npairs, int extra);
    int given = 0;
    while (given < npairs + extra) begin
      bit t = ($urandom % 3) != 0;
      step(0, 1, t);
      if (t) given++;
    end
    step(0, 1, 0);
    for (int g = 0; g < 3; g++) step(0, 0, ($urandom % 2) == 1);
  endtask

  task automatic frame(int vs_len, int lines, int short_at, int extra_at);
    for (int i = 0; i < vs_len; i++) step(1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    for (int l = 0; l < lines; l++)
      line(l == short_at ? PAIRS - 3 : PAIRS, l == extra_at ? 4 : 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({out_valid, eol, eof, short_l, overrun, ovf, field_odd} == 7'd0, "R1 reset outputs",
        {out_valid, eol, eof, short_l, overrun, ovf, field_odd}, 0);
    chk(orow == 0 && ocol == 0 && s0 == 0 && s1 == 0, "R1 reset data", {orow, ocol}, 0);
    checking = 1;
    frame(ODD_MIN + 2, ROWS, -1, -1);     // odd field, full frame (R3 R7 R11)
    frame(ODD_MIN - 3, ROWS, -1, -1);     // even field
    frame(ODD_MIN, ROWS, 1, -1);          // short line (R8), exact threshold
    frame(ODD_MIN - 1, ROWS, -1, 2);      // extra ticks ignored (R5)
    frame(ODD_MIN + 1, ROWS + 2, -1, -1); // too many lines (R9)
    frame(2, 2, -1, -1);                  // frame cut short, restart (R4)
    frame(ODD_MIN, ROWS, -1, -1);
    ready_mode = 1;
    for (int f = 0; f < 12; f++)
      frame(2 + ($urandom % 8), ROWS - 1 + ($urandom % 3),
            ($urandom % 4 == 0) ? int'($urandom % ROWS) : -1,
            ($urandom % 4 == 0) ? int'($urandom % ROWS) : -1);
    ready_mode = 2;                       // stall: drops (R10)
    frame(ODD_MIN, 2, -1, -1);
    ready_mode = 1;
    frame(3, ROWS, -1, -1);
    step(0, 0, 0); step(0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule